// File: doc/BRIEF.md
# Hot-Plug Slot Status Poll Scheduler

This block paces the background scan of a hot-plug slot controller. A coarse timebase pulse (`tick_i`) drives a sleep window between scan rounds. Most rounds are cheap: the block reads the controller's latch byte and compares it with the copy kept from the previous round. For every slot whose latch bit changed, it reads that slot's status and extended status bytes, then reports an event.

After a fixed number of rounds, the block runs a full round instead. A full round reads the status pair of every slot in the configured range and reports only the slots whose bytes differ from the stored copy. It then refreshes the latch copy without comparing it.

Reads leave the block through a request/acknowledge port, which goes to a separate controller access engine. Events carry the slot number together with the old and new `{extended, status}` byte pairs. Raising `stop_i` ends the scan at the next sleep window, so a round that is in progress always completes.

Top module: `hp_poll_sched`

## Requirements
- R1: After reset the stored latch, status and extended status bytes are all 0x00, no event is reported and `stopped_o` is 0. The first action is a latch read request (kind 0, slot 0).
- R2: After each round the block issues no request until `SLEEP_TICKS` (default 2) `tick_i` pulses have been seen in the sleep window. Ticks that arrive during a round have no effect on the sleep length.
- R3: A poll counter starts at 0 and adds one after every round. When a sleep window ends, a counter of `FULL_EVERY` (default 5) or more clears the counter and starts a full round; any lower value starts a latch round. The round after reset is a latch round.
- R4: A latch round reads the latch byte (kind 0, slot 0). Bit s of that byte belongs to slot s, and bit 0 is reserved. For each slot s from `first_slot_i` up to `last_slot_i`, in ascending order, whose bit differs from the previously stored latch byte, the block reads status (kind 1) and then extended status (kind 2) of slot s. It then reports an event whether or not the bytes changed. Bits outside the range cause no reads.
- R5: A full round reads status and then extended status for every slot in the range, in ascending order. It reports an event only when the new pair differs from the stored pair. It then reads the latch byte, which updates the stored latch with no event.
- R6: At most one read is outstanding. While `rd_req_o` is high without `rd_ack_i`, the request stays high and `rd_kind_o` and `rd_slot_o` hold. A new request starts only after the previous acknowledge.
- R7: `stop_i` acts only in the sleep window. A round in progress completes. After that, `stopped_o` is 1 and no request or event appears until reset.
- R8: Event fields: `evt_old_o` is `{stored ext, stored status}` and `evt_new_o` is `{read ext, read status}`. After the event the stored pair takes the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| stop_i | input | 1 | Level request to end polling |
| first_slot_i | input | SLOT_W | Lowest slot number scanned (1 or more) |
| last_slot_i | input | SLOT_W | Highest slot number scanned (NUM_SLOTS or less) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_kind_o | output | 2 | 0 latch byte, 1 status, 2 extended status |
| rd_slot_o | output | SLOT_W | Slot of a status read, 0 for a latch read |
| rd_ack_i | input | 1 | Read complete, data valid this cycle |
| rd_data_i | input | DATA_W | Read data |
| evt_valid_o | output | 1 | Change event, one cycle |
| evt_slot_o | output | SLOT_W | Slot of the event |
| evt_old_o | output | 2*DATA_W | Stored `{ext, status}` before the event |
| evt_new_o | output | 2*DATA_W | Freshly read `{ext, status}` |
| stopped_o | output | 1 | Polling has ended |

## Verification
The assertions assume a well-behaved access engine. It raises `rd_ack_i` only while a request is pending, for exactly one cycle. The slot range obeys 1 ≤ first ≤ last ≤ NUM_SLOTS and changes only during a sleep window.

The bench's responder acknowledges only a request it has already seen. It rotates the response delay through zero to three cycles, including back-to-back requests. The bench alters the slot bytes, the latch byte and the range only while the block sleeps. Ticks and the stop level are placed both inside rounds and inside sleep windows, to show where each one takes effect.

// File: rtl/hp_poll_pkg.sv
package hp_poll_pkg;
  typedef enum logic [1:0] {
    RD_LATCH = 2'd0,
    RD_STAT  = 2'd1,
    RD_EXT   = 2'd2
  } rd_kind_e;

  typedef enum logic [2:0] {
    S_LATCH,
    S_PICK,
    S_STAT,
    S_EXT,
    S_EMIT,
    S_RELATCH,
    S_SLEEP,
    S_HALT
  } poll_state_e;
endpackage

// File: rtl/hp_poll_timer.sv
module hp_poll_timer #(
  parameter int SLEEP_TICKS = 2,
  parameter int FULL_EVERY  = 5,
  localparam int TW = $clog2(SLEEP_TICKS + 1),
  localparam int PW = $clog2(FULL_EVERY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleeping_i,
  input  logic tick_i,
  input  logic wake_i,
  input  logic poll_done_i,
  output logic last_tick_o,
  output logic full_due_o
);
  logic [TW-1:0] sl_q;
  logic [PW-1:0] pc_q;

  assign last_tick_o = tick_i && (sl_q == TW'(SLEEP_TICKS - 1));
  assign full_due_o  = (pc_q >= PW'(FULL_EVERY));

  // sleep window counter only runs while sleeping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sl_q <= '0;
    else if (!sleeping_i || wake_i) sl_q <= '0;
    else if (tick_i)                sl_q <= sl_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pc_q <= '0;
    else if (wake_i && full_due_o)  pc_q <= '0;
    else if (poll_done_i)           pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/hp_slot_pick.sv
module hp_slot_pick #(
  parameter int N = 7,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    any_o = |mask_i;
    idx_o = '0;
    for (int b = N - 1; b >= 0; b--) begin
      if (mask_i[b]) idx_o = IW'(b);
    end
  end
endmodule

// File: rtl/hp_slot_store.sv
module hp_slot_store #(
  parameter int NUM_SLOTS = 6,
  parameter int DATA_W    = 8,
  localparam int SW = $clog2(NUM_SLOTS + 1),
  localparam int EW = 2 * DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_slot_i,
  input  logic [EW-1:0] wr_ent_i,
  input  logic [SW-1:0] rd_slot_i,
  output logic [EW-1:0] rd_ent_o
);
  logic [EW-1:0] ent [NUM_SLOTS+1];

  for (genvar g = 0; g <= NUM_SLOTS; g++) begin : g_ent
    if (g == 0) begin : g_rsvd
      assign ent[g] = '0;
    end else begin : g_slot
      logic [EW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= '0;
        else if (wr_en_i && wr_slot_i == SW'(g))     q <= wr_ent_i;
      end
      assign ent[g] = q;
    end
  end

  assign rd_ent_o = (32'(rd_slot_i) <= NUM_SLOTS) ? ent[rd_slot_i] : '0;
endmodule

// File: rtl/hp_poll_sched.sv
module hp_poll_sched #(
  parameter int NUM_SLOTS   = 6,
  parameter int DATA_W      = 8,
  parameter int SLEEP_TICKS = 2,
  parameter int FULL_EVERY  = 5,
  localparam int SLOT_W  = $clog2(NUM_SLOTS + 1),
  localparam int LATCH_W = NUM_SLOTS + 1,
  localparam int EVT_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              stop_i,
  input  logic [SLOT_W-1:0] first_slot_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output logic              rd_req_o,
  output logic [1:0]        rd_kind_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              evt_valid_o,
  output logic [SLOT_W-1:0] evt_slot_o,
  output logic [EVT_W-1:0]  evt_old_o,
  output logic [EVT_W-1:0]  evt_new_o,
  output logic              stopped_o
);
  import hp_poll_pkg::*;

  poll_state_e        state_q;
  logic [LATCH_W-1:0] latch_q, pend_q, range_mask, new_latch;
  logic [SLOT_W-1:0]  cur_q, pick_idx;
  logic [DATA_W-1:0]  nstat_q, next_q;
  logic               full_q, pick_any;
  logic               sleeping, wake, last_tick, full_due, poll_done;
  logic [EVT_W-1:0]   stored_ent;
  logic               changed;

  assign new_latch = rd_data_i[LATCH_W-1:0];

  // slots covered by the configured range; bit 0 is reserved
  always_comb begin
    for (int b = 0; b < LATCH_W; b++) begin
      range_mask[b] = (b != 0) && (SLOT_W'(b) >= first_slot_i) && (SLOT_W'(b) <= last_slot_i);
    end
  end

  hp_slot_pick #(.N(LATCH_W)) u_pick (
    .mask_i (pend_q),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  assign sleeping  = (state_q == S_SLEEP);
  assign wake      = sleeping && !stop_i && last_tick;
  assign poll_done = ((state_q == S_PICK) && !pick_any && !full_q) ||
                     ((state_q == S_RELATCH) && rd_ack_i);

  hp_poll_timer #(.SLEEP_TICKS(SLEEP_TICKS), .FULL_EVERY(FULL_EVERY)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleeping_i  (sleeping),
    .tick_i      (tick_i),
    .wake_i      (wake),
    .poll_done_i (poll_done),
    .last_tick_o (last_tick),
    .full_due_o  (full_due)
  );

  hp_slot_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (state_q == S_EMIT),
    .wr_slot_i (cur_q),
    .wr_ent_i  ({next_q, nstat_q}),
    .rd_slot_i (cur_q),
    .rd_ent_o  (stored_ent)
  );

  assign changed = (stored_ent != {next_q, nstat_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_LATCH;
      latch_q <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
      nstat_q <= '0;
      next_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      case (state_q)
        S_LATCH: if (rd_ack_i) begin
          pend_q  <= (latch_q ^ new_latch) & range_mask;
          latch_q <= new_latch;
          full_q  <= 1'b0;
          state_q <= S_PICK;
        end
        S_PICK: begin
          if (pick_any) begin
            cur_q   <= pick_idx;
            pend_q  <= pend_q & ~(LATCH_W'(1) << pick_idx);
            state_q <= S_STAT;
          end else if (full_q) begin
            state_q <= S_RELATCH;
          end else begin
            state_q <= S_SLEEP;
          end
        end
        S_STAT: if (rd_ack_i) begin
          nstat_q <= rd_data_i;
          state_q <= S_EXT;
        end
        S_EXT: if (rd_ack_i) begin
          next_q  <= rd_data_i;
          state_q <= S_EMIT;
        end
        S_EMIT: state_q <= S_PICK;
        S_RELATCH: if (rd_ack_i) begin
          latch_q <= new_latch;  // refreshed without comparison
          state_q <= S_SLEEP;
        end
        S_SLEEP: begin
          if (stop_i) begin
            state_q <= S_HALT;
          end else if (wake) begin
            if (full_due) begin
              full_q  <= 1'b1;
              pend_q  <= range_mask;
              state_q <= S_PICK;
            end else begin
              state_q <= S_LATCH;
            end
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  always_comb begin
    rd_req_o  = 1'b0;
    rd_kind_o = RD_LATCH;
    rd_slot_o = '0;
    case (state_q)
      S_LATCH, S_RELATCH: rd_req_o = 1'b1;
      S_STAT: begin rd_req_o = 1'b1; rd_kind_o = RD_STAT; rd_slot_o = cur_q; end
      S_EXT:  begin rd_req_o = 1'b1; rd_kind_o = RD_EXT;  rd_slot_o = cur_q; end
      default: ;
    endcase
  end

  assign evt_valid_o = (state_q == S_EMIT) && (!full_q || changed);
  assign evt_slot_o  = cur_q;
  assign evt_old_o   = stored_ent;
  assign evt_new_o   = {next_q, nstat_q};
  assign stopped_o   = (state_q == S_HALT);
endmodule

// File: rtl/hp_poll_sched_chk.sv
module hp_poll_sched_chk #(
  parameter int SLOT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] first_slot_i,
  input logic [SLOT_W-1:0] last_slot_i,
  input logic              rd_req_o,
  input logic [1:0]        rd_kind_o,
  input logic [SLOT_W-1:0] rd_slot_o,
  input logic              rd_ack_i,
  input logic              evt_valid_o,
  input logic              stopped_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_kind_o) && $stable(rd_slot_o)); // R6

  AST_EVT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> !rd_req_o); // R6

  AST_EVT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o); // R4

  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_kind_o != 2'd0 |-> rd_slot_o >= first_slot_i && rd_slot_o <= last_slot_i); // R4

  AST_LATCH_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_kind_o == 2'd0 |-> rd_slot_o == '0); // R4

  AST_HALT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !rd_req_o && !evt_valid_o); // R7

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |=> stopped_o); // R7
endmodule

bind hp_poll_sched hp_poll_sched_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .first_slot_i (first_slot_i),
  .last_slot_i  (last_slot_i),
  .rd_req_o     (rd_req_o),
  .rd_kind_o    (rd_kind_o),
  .rd_slot_o    (rd_slot_o),
  .rd_ack_i     (rd_ack_i),
  .evt_valid_o  (evt_valid_o),
  .stopped_o    (stopped_o)
);

// File: tb/tb_hp_poll_sched.sv
`timescale 1ns/1ps
module tb_hp_poll_sched;
  localparam int NS = 6;
  localparam int DW = 8;
  localparam int SW = 3;
  localparam int ST = 2;
  localparam int FE = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [SW-1:0] first_slot_i = 3'd1;
  logic [SW-1:0] last_slot_i = 3'd6;
  logic          rd_req_o;
  logic [1:0]    rd_kind_o;
  logic [SW-1:0] rd_slot_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          evt_valid_o;
  logic [SW-1:0] evt_slot_o;
  logic [15:0]   evt_old_o, evt_new_o;
  logic          stopped_o;

  hp_poll_sched #(.NUM_SLOTS(NS), .DATA_W(DW), .SLEEP_TICKS(ST), .FULL_EVERY(FE)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
    .first_slot_i(first_slot_i), .last_slot_i(last_slot_i),
    .rd_req_o(rd_req_o), .rd_kind_o(rd_kind_o), .rd_slot_o(rd_slot_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .evt_valid_o(evt_valid_o), .evt_slot_o(evt_slot_o),
    .evt_old_o(evt_old_o), .evt_new_o(evt_new_o), .stopped_o(stopped_o)
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    int          kind;  // 0 latch, 1 status, 2 ext, 3 event
    int          slot;
    logic [15:0] o;
    logic [15:0] n;
    string       tag;
  } item_t;

  item_t      exp_q[$];
  int         checks = 0, failures = 0;
  string      quiet_tag = "R2";
  logic [7:0] env_latch, m_latch;
  logic [7:0] env_stat[8], env_ext[8], m_stat[8], m_ext[8];
  int         m_cnt = 0;
  bit         pend = 0, done = 0;
  int         pk, ps, wait_left, dly = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(int k, int s, logic [15:0] o, logic [15:0] n, string tag);
    item_t it;
    it.kind = k; it.slot = s; it.o = o; it.n = n; it.tag = tag;
    exp_q.push_back(it);
  endfunction

  task automatic see(input int kind, input int slot, input logic [15:0] o, input logic [15:0] n);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, quiet_tag, "unexpected activity kind", kind, -1);
      return;
    end
    it = exp_q.pop_front();
    chk(kind == it.kind && slot == it.slot, it.tag, "kind*16+slot", kind * 16 + slot, it.kind * 16 + it.slot);
    if (kind == 3) chk(o == it.o && n == it.n, it.tag, "event {old,new}", {o, n}, {it.o, it.n});
  endtask

  // behavioural model of one round, built from requirements R3 R4 R5 R8
  function automatic void build_round(bit full);
    int f = int'(first_slot_i);
    int l = int'(last_slot_i);
    if (!full) begin
      push(0, 0, 0, 0, "R3");
      for (int s = f; s <= l; s++) begin
        if (m_latch[s] != env_latch[s]) begin
          push(1, s, 0, 0, "R4");
          push(2, s, 0, 0, "R4");
          push(3, s, {m_ext[s], m_stat[s]}, {env_ext[s], env_stat[s]}, "R8");
          m_stat[s] = env_stat[s];
          m_ext[s]  = env_ext[s];
        end
      end
    end else begin
      for (int s = f; s <= l; s++) begin
        push(1, s, 0, 0, (s == f) ? "R3" : "R5");
        push(2, s, 0, 0, "R5");
        if ({m_ext[s], m_stat[s]} != {env_ext[s], env_stat[s]})
          push(3, s, {m_ext[s], m_stat[s]}, {env_ext[s], env_stat[s]}, "R5");
        m_stat[s] = env_stat[s];
        m_ext[s]  = env_ext[s];
      end
      push(0, 0, 0, 0, "R5");
    end
    m_latch = env_latch;
    m_cnt++;
  endfunction

  // responder and per-cycle comparison
  initial begin : responder
    forever begin
      @(negedge clk_i);
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
        pend = 0;
      end
      if (!rst_ni) begin
        pend = 0;
      end else begin
        if (evt_valid_o) see(3, int'(evt_slot_o), evt_old_o, evt_new_o);
        if (rd_req_o && !pend) begin
          see(int'(rd_kind_o), int'(rd_slot_o), 16'h0, 16'h0);
          pend = 1; pk = int'(rd_kind_o); ps = int'(rd_slot_o);
          wait_left = dly; dly = (dly + 1) % 4;
        end
        if (pend && !rd_ack_i) begin
          if (wait_left == 0) begin
            chk(rd_req_o && int'(rd_kind_o) == pk && int'(rd_slot_o) == ps, "R6",
                "held request kind*16+slot", int'(rd_kind_o) * 16 + int'(rd_slot_o), pk * 16 + ps);
            case (rd_kind_o)
              2'd0:    rd_data_i = env_latch;
              2'd1:    rd_data_i = env_stat[rd_slot_o];
              default: rd_data_i = env_ext[rd_slot_o];
            endcase
            rd_ack_i = 1'b1;
          end else begin
            wait_left--;
          end
        end
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0 || pend) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  // R2: sleep window; expected round is queued only at the final tick
  task automatic sleep_and_wake(input bit build, input bit long_tick);
    for (int k = 1; k <= ST; k++) begin
      if (k == ST && build) begin
        if (m_cnt >= FE) begin
          m_cnt = 0;
          build_round(1'b1);
        end else begin
          build_round(1'b0);
        end
      end
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) if (!(k == ST && long_tick)) tick_i = 1'b0;
      if (k == ST && long_tick) @(negedge clk_i) tick_i = 1'b0;  // R2 tick inside a round
      if (k < ST) repeat (6) @(negedge clk_i);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    for (int s = 0; s < 8; s++) begin
      env_stat[s] = '0; env_ext[s] = '0; m_stat[s] = '0; m_ext[s] = '0;
    end
    m_latch   = 8'h00;
    env_latch = 8'h87;  // bit 0 and bit 7 outside any slot
    env_stat[1] = 8'h11; env_ext[1] = 8'h21;
    env_stat[2] = 8'h12; env_ext[2] = 8'h22;
    env_stat[3] = 8'h13;
    build_round(1'b0);  // R1 first round is a latch round, stored bytes 0x00
    repeat (3) @(negedge clk_i);
    chk(evt_valid_o == 1'b0, "R1", "evt_valid_o in reset", int'(evt_valid_o), 0);
    chk(stopped_o == 1'b0, "R1", "stopped_o in reset", int'(stopped_o), 0);
    rst_ni = 1'b1;
    drain();

    for (int r = 1; r <= 13; r++) begin
      env_latch = 8'(r * 37 + 1);
      env_stat[(r % NS) + 1] = 8'(r * 13 + 7);
      if (r % 2 == 0) env_ext[(r % NS) + 1] = 8'(r * 29 + 3);
      if (r == 7)  begin first_slot_i = 3'd2; last_slot_i = 3'd4; end
      if (r == 11) begin first_slot_i = 3'd3; last_slot_i = 3'd6; end
      sleep_and_wake(1'b1, r == 3 || r == 10);
      drain();
      chk(stopped_o == 1'b0, "R7", "stopped_o while running", int'(stopped_o), 0);
    end

    // R7: stop raised inside a round takes effect only at the sleep window
    env_latch = 8'h5a;
    env_stat[4] = 8'hc4;
    sleep_and_wake(1'b1, 1'b0);
    stop_i = 1'b1;
    drain();
    quiet_tag = "R7";
    chk(stopped_o == 1'b1, "R7", "stopped_o after round", int'(stopped_o), 1);
    repeat (3) sleep_and_wake(1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk(stopped_o == 1'b1 && rd_req_o == 1'b0, "R7", "halted {stopped,req}",
        {30'd0, stopped_o, rd_req_o}, 2);
    chk(exp_q.size() == 0, "R5", "leftover expected items", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule